// File: doc/BRIEF.md
# Dithered High-Resolution PWM Converter

The block turns a wide setpoint into a single pulse-width-modulated pin whose long-run average duty cycle carries more resolution than the PWM counter itself. The setpoint is `DUTY_W + FRAC_W` bits wide, 32 bits by default. Its upper part, rounded half-up, becomes a base duty for a `DUTY_W`-bit period counter. The part lost in rounding is kept as a signed residual of `FRAC_W` fractional bits.

Once per PWM period, a first-order accumulator adds the residual magnitude. Each carry out of the accumulator moves the duty of the following period by one count, toward the residual's sign. Over `2^FRAC_W` periods the mean duty then tracks the full setpoint. An external RC filter turns the pin into an analog level.

A setpoint is written with a one-cycle load strobe. A small load controller with states ST_IDLE, ST_PENDING and ST_ACTIVE holds the new value in a shadow register. The transitions are:
- ST_IDLE to ST_PENDING on a load.
- ST_PENDING to ST_ACTIVE at the next period boundary, where the value is applied and the accumulator restarts.
- ST_ACTIVE to ST_PENDING on a later load.
- A load that arrives while in ST_PENDING replaces the pending value and stays in ST_PENDING.

The dither enable selects between the dithered output and the plain rounded PWM.

Top module: `hires_pwm_dac`

## Requirements
- R1: The base duty is the upper `DUTY_W` bits of the setpoint, rounded half-up on bit `FRAC_W-1`. For example, with 4+4 bits, 0x28 gives 3 and 0x37 gives 3.
- R2: With `dith_en` low at a period boundary, the next period's duty equals the base duty exactly, whatever the residual.
- R3: With dithering on, every period's duty is the base duty, or base+1 when the residual is positive, or base-1 when it is negative. No other value occurs.
- R4: With dithering on and no saturation, the sum of the duties over the `2^FRAC_W` periods that follow a load equals the setpoint within one count.
- R5: When rounding would exceed full scale, the base duty clips to all ones. Positive corrections never raise it further or wrap it, so every period is high for `2^DUTY_W-1` cycles.
- R6: The duty changes only at a period start, which is the cycle where the counter reads 0. A load mid-period leaves the rest of that period unchanged, and the new value governs from the next period start. Changing `set_val` without a strobe has no effect.
- R7: A load restarts the accumulator. The first period after the swap carries no correction, and the correction pattern that follows depends only on the new residual.
- R8: After reset the counter is 0, the duty is 0 and the pin stays low until a setpoint is loaded.
- R9: Within each period the pin is high for the first `duty` cycles, counter values 0 to duty-1, and low for the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_val | input | DUTY_W+FRAC_W | Setpoint, duty counts with FRAC_W fractional bits |
| set_load | input | 1 | One-cycle strobe capturing `set_val` |
| dith_en | input | 1 | 1 = fractional dithering, 0 = plain rounded PWM |
| pwm_o | output | 1 | PWM output pin |

## Verification
A corrupted shadow duty shows within a single period as a wrong high time or as a step outside base±1. A faulty accumulator or sign decision leaves each period legal but shifts the total high time over `2^FRAC_W` periods by more than one count. The mean must therefore be measured over a full window right after the load, when the accumulator starting point is known. A stuck load controller shows at the next boundary as an old duty that persists, or as a setpoint that is applied mid-period.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PENDING = 2'd1,
        ST_ACTIVE  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/hpd_period_ctr.sv
module hpd_period_ctr #(
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] cnt_q,
    output logic              period_end
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + DUTY_W'(1);
    end

    assign period_end = &cnt_q;

endmodule

// File: rtl/hpd_splitter.sv
module hpd_splitter #(
    parameter int DUTY_W = 16,
    parameter int FRAC_W = 16,
    localparam int SET_W = DUTY_W + FRAC_W
) (
    input  logic [SET_W-1:0]  sp,
    output logic [DUTY_W-1:0] base,
    output logic [FRAC_W-1:0] mag,
    output logic              neg
);

    logic [DUTY_W:0]   hi_w;
    logic              sat_w;
    logic [FRAC_W-1:0] lo_w;

    // half-up rounding: add the top fractional bit into the integer part
    assign hi_w  = {1'b0, sp[SET_W-1:FRAC_W]} + (DUTY_W+1)'(sp[FRAC_W-1]);
    assign sat_w = hi_w[DUTY_W];
    assign lo_w  = sp[FRAC_W-1:0];

    always_comb begin
        base = sat_w ? '1 : hi_w[DUTY_W-1:0];
        // rounded up without clipping -> residual is lo - 2^F (negative)
        neg  = sp[FRAC_W-1] && !sat_w;
        mag  = neg ? (~lo_w + FRAC_W'(1)) : lo_w;
    end

endmodule

// File: rtl/hpd_dither_acc.sv
module hpd_dither_acc #(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clear,
    input  logic              en,
    input  logic [FRAC_W-1:0] mag,
    output logic              carry_q
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum_w;

    assign sum_w = {1'b0, (clear ? '0 : acc_q)} + {1'b0, mag};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (step) begin
            if (!en) begin
                acc_q   <= '0;
                carry_q <= 1'b0;
            end else begin
                acc_q   <= sum_w[FRAC_W-1:0];
                carry_q <= sum_w[FRAC_W];
            end
        end
    end

endmodule

// File: rtl/hires_pwm_dac.sv
module hires_pwm_dac
    import hpd_pkg::*;
#(
    parameter int DUTY_W = 16,
    parameter int FRAC_W = 16,
    localparam int SET_W = DUTY_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_val,
    input  logic             set_load,
    input  logic             dith_en,
    output logic             pwm_o
);

    ld_state_e         state_q, state_d;
    logic [SET_W-1:0]  pend_q, act_q, act_next;
    logic [DUTY_W-1:0] cnt_q, duty_q, duty_next, base_w;
    logic [FRAC_W-1:0] mag_w;
    logic              neg_w, period_end, swap, carry_q, corr;

    hpd_period_ctr #(.DUTY_W(DUTY_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_q      (cnt_q),
        .period_end (period_end)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (set_load) state_d = ST_PENDING;
            ST_PENDING: if (!set_load && period_end) state_d = ST_ACTIVE;
            ST_ACTIVE:  if (set_load) state_d = ST_PENDING;
            default:    state_d = ST_IDLE;
        endcase
    end

    // controller outputs
    always_comb begin
        swap = period_end && (state_q == ST_PENDING);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (set_load) pend_q <= set_val;
            if (swap)     act_q  <= pend_q;
        end
    end

    assign act_next = swap ? pend_q : act_q;

    hpd_splitter #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_split (
        .sp   (act_next),
        .base (base_w),
        .mag  (mag_w),
        .neg  (neg_w)
    );

    hpd_dither_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (period_end),
        .clear   (swap),
        .en      (dith_en),
        .mag     (mag_w),
        .carry_q (carry_q)
    );

    assign corr = dith_en && carry_q && !swap;

    always_comb begin
        duty_next = base_w;
        if (corr) begin
            if (neg_w) duty_next = (base_w == '0) ? '0 : base_w - DUTY_W'(1);
            else       duty_next = (&base_w) ? base_w : base_w + DUTY_W'(1);
        end
    end

    // shadow duty: only reloaded as a new period begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          duty_q <= '0;
        else if (period_end) duty_q <= duty_next;
    end

    assign pwm_o = (cnt_q < duty_q);

endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
    parameter int DUTY_W = 16,
    parameter int FRAC_W = 16,
    localparam int SET_W = DUTY_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dith_en,
    input logic              pwm_o,
    input logic [DUTY_W-1:0] cnt_q,
    input logic [DUTY_W-1:0] duty_q,
    input logic [SET_W-1:0]  act_q
);

    logic [DUTY_W:0]   ref_hi;
    logic              ref_sat, ref_pos, ref_neg;
    logic [DUTY_W-1:0] ref_base;

    assign ref_hi   = {1'b0, act_q[SET_W-1:FRAC_W]} + (DUTY_W+1)'(act_q[FRAC_W-1]);
    assign ref_sat  = ref_hi[DUTY_W];
    assign ref_base = ref_sat ? '1 : ref_hi[DUTY_W-1:0];
    assign ref_neg  = act_q[FRAC_W-1] && !ref_sat;
    assign ref_pos  = (act_q[FRAC_W-1:0] != '0) && !ref_neg;

    // R6: shadow duty only moves at a period start
    a_r6_duty_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(duty_q));

    // R3: at most one count away from base, in the residual's direction
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> ((duty_q == ref_base)
            || (ref_pos && ({1'b0, duty_q} == {1'b0, ref_base} + (DUTY_W+1)'(1)))
            || (ref_neg && ({1'b0, duty_q} + (DUTY_W+1)'(1) == {1'b0, ref_base}))));

    // R5: clipped base stays at full scale
    a_r5_top_clip: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && ref_sat) |-> (&duty_q));

    // R2: dither off gives the plain rounded duty
    a_r2_plain_duty: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && !$past(dith_en)) |-> (duty_q == ref_base));

    // R9: once low within a period, the pin stays low until the period ends
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q != '0) && !$past(pwm_o)) |-> !pwm_o);

endmodule

bind hires_pwm_dac hpd_checker #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dith_en (dith_en),
    .pwm_o   (pwm_o),
    .cnt_q   (cnt_q),
    .duty_q  (duty_q),
    .act_q   (act_q)
);

// File: tb/hires_pwm_dac_tb.sv
`timescale 1ns/1ps
module hires_pwm_dac_tb;

    localparam int D   = 4;
    localparam int F   = 4;
    localparam int S   = D + F;
    localparam int PER = 1 << D;
    localparam int NP  = 1 << F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [S-1:0] set_val = '0;
    logic         set_load = 1'b0;
    logic         dith_en = 1'b0;
    logic         pwm_o;
    int           cyc;
    int           tests = 0;
    int           fails = 0;

    always #2.5 clk = ~clk;

    hires_pwm_dac #(.DUTY_W(D), .FRAC_W(F)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_val  (set_val),
        .set_load (set_load),
        .dith_en  (dith_en),
        .pwm_o    (pwm_o)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // load a value, return at the negedge just after the swap boundary (counter = 0)
    task automatic load_align(input logic [S-1:0] v, input logic en);
        int c;
        @(negedge clk);
        set_val  = v;
        dith_en  = en;
        set_load = 1'b1;
        @(negedge clk);
        set_load = 1'b0;
        c = cyc;
        while (!((cyc % PER == 0) && (cyc > c))) @(negedge clk);
    endtask

    task automatic grab(output int hi, output bit shape_ok);
        bit seen_low = 1'b0;
        hi = 0;
        shape_ok = 1'b1;
        for (int i = 0; i < PER; i++) begin
            if (pwm_o) begin
                hi++;
                if (seen_low) shape_ok = 1'b0;
            end else begin
                seen_low = 1'b1;
            end
            @(negedge clk);
        end
    endtask

    task automatic window(input logic [S-1:0] v, input logic en, input int lo,
                          input int hi, input bit do_avg, input string req);
        int sum = 0;
        int bad = 0;
        int first_bad = 0;
        bit shape_all = 1'b1;
        int h;
        bit sh;
        load_align(v, en);
        for (int p = 0; p < NP; p++) begin
            grab(h, sh);
            sum += h;
            if (!sh) shape_all = 1'b0;
            if (h < lo || h > hi) begin
                if (bad == 0) first_bad = h;
                bad++;
            end
        end
        chk(bad == 0, req, $sformatf("period high count for 0x%0h", v), first_bad, lo);
        chk(shape_all, "R9", $sformatf("pulse shape for 0x%0h", v), 0, 1);
        if (do_avg)
            chk((sum - int'(v) <= 1) && (int'(v) - sum <= 1), "R4",
                $sformatf("window sum for 0x%0h", v), sum, int'(v));
    endtask

    task automatic test_reset();
        int hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        chk(hi == 0, "R8", "high cycles before first load", hi, 0);
    endtask

    task automatic test_plain();
        window(8'h35, 1'b0, 3, 3, 1'b0, "R2");
        window(8'h3B, 1'b0, 4, 4, 1'b0, "R2");
        window(8'h28, 1'b0, 3, 3, 1'b0, "R1");
        window(8'h37, 1'b0, 3, 3, 1'b0, "R1");
    endtask

    task automatic test_dither();
        window(8'h35, 1'b1, 3, 4, 1'b1, "R3");
        window(8'h3B, 1'b1, 3, 4, 1'b1, "R3");
        window(8'h38, 1'b1, 3, 4, 1'b1, "R3");
        window(8'h01, 1'b1, 0, 1, 1'b1, "R3");
        window(8'h00, 1'b1, 0, 0, 1'b1, "R3");
        window(8'h80, 1'b1, 8, 8, 1'b1, "R3");
    endtask

    task automatic test_clip();
        window(8'hFF, 1'b1, 15, 15, 1'b0, "R5");
        window(8'hF8, 1'b1, 15, 15, 1'b0, "R5");
        window(8'hF7, 1'b1, 15, 15, 1'b0, "R5");
    endtask

    task automatic test_load_timing();
        load_align(8'h20, 1'b0);
        while (cyc % PER != 3) @(negedge clk);
        set_val  = 8'hC0;
        set_load = 1'b1;
        @(negedge clk);
        set_load = 1'b0;
        set_val  = 8'h00;   // no strobe: must be ignored
        @(negedge clk);
        @(negedge clk);
        chk(pwm_o == 1'b0, "R6", "old duty kept at count 6", int'(pwm_o), 0);
        while (cyc % PER != 15) @(negedge clk);
        chk(pwm_o == 1'b0, "R6", "old duty kept at count 15", int'(pwm_o), 0);
        while (cyc % PER != 6) @(negedge clk);
        chk(pwm_o == 1'b1, "R6", "new duty at count 6", int'(pwm_o), 1);
        while (cyc % PER != 11) @(negedge clk);
        chk(pwm_o == 1'b1, "R6", "new duty at count 11", int'(pwm_o), 1);
        @(negedge clk);
        chk(pwm_o == 1'b0, "R6", "new duty ends at count 12", int'(pwm_o), 0);
    endtask

    task automatic test_restart();
        int h;
        bit sh;
        load_align(8'h38, 1'b1);
        grab(h, sh);
        chk(h == 4, "R7", "first run period 0", h, 4);
        grab(h, sh);
        chk(h == 4, "R7", "first run period 1", h, 4);
        load_align(8'h38, 1'b1);   // captured mid period 2, swap at the next boundary
        grab(h, sh);
        chk(h == 4, "R7", "reload period 0", h, 4);
        grab(h, sh);
        chk(h == 4, "R7", "reload period 1", h, 4);
        grab(h, sh);
        chk(h == 3, "R7", "reload period 2", h, 3);
    endtask

    initial begin
        #1_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_plain();
        test_dither();
        test_clip();
        test_load_timing();
        test_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule